// File: doc/BRIEF.md
# Eight-bit ALU with selective status-flag update

This block is the arithmetic and logic datapath of a small single-cycle eight-bit core. The core selects an operation with `op_code` and presents two operands: `opnd_d` is the destination register value, and `opnd_r` is either a second register or an immediate that the decoder has already selected. The block returns the eight-bit result, a write strobe for that result, and a new six-bit status vector. The vector is formed from the incoming status `flags_in`, so the incoming carry is `flags_in[0]`.

Each operation class rewrites only its own group of status bits. Every other bit is copied from `flags_in` unchanged. The operations are add and subtract with and without carry, compare, negate, the bitwise operations, complement, increment, decrement, test, shifts, rotates through carry, arithmetic right shift, nibble swap and set-all. Subtract-with-carry and compare-with-carry only ever clear the zero bit, so that comparisons spanning several bytes chain correctly. A status register inside the block loads the new vector on each cycle in which `op_valid` is high.

Flag vector positions used by every port: bit 0 carry (C), bit 1 zero (Z), bit 2 negative (N), bit 3 overflow (V), bit 4 sign (S), bit 5 half carry (H). Operation codes: 0 add, 1 add with carry, 2 subtract, 3 subtract with carry, 4 compare, 5 compare with carry, 6 negate, 7 and, 8 or, 9 xor, 10 complement, 11 increment, 12 decrement, 13 test, 14 shift left, 15 shift right, 16 rotate left, 17 rotate right, 18 arithmetic shift right, 19 swap, 20 set all. Codes 21 to 31 are unused.

Top module: `alu8_flags`

## Requirements
- R1: While `rst_n` is low at a clock edge, `flags_q` becomes 0.
- R2: Codes 0 and 1 give result = d + r (+ C for code 1) mod 256. C is the carry out of bit 7, H is the carry out of bit 3, V is two's-complement overflow, N is result bit 7, Z is (result == 0) and S = N xor V. All six bits are written.
- R3: Codes 2, 3 and 6 give d − r (− C for code 3), and 0 − d for code 6. C is the borrow out of bit 7, H is the borrow out of bit 3, and V, N and S follow the signed difference. All six bits are written and `result_we` is 1.
- R4: For codes 3 and 5, Z is 1 only if the result is zero and `flags_in[1]` is 1. A nonzero result clears Z, and a zero result keeps the previous Z.
- R5: Codes 4 and 5 set the flags exactly as codes 2 and 3 do and show the difference on `result`, but hold `result_we` at 0.
- R6: Codes 7, 8, 9 and 13 (13 passes d through) write S, V, N and Z with V = 0. C and H keep the values of `flags_in`.
- R7: Code 11 (d + 1) sets V only for input 0x7F, and code 12 (d − 1) sets V only for input 0x80. Both write only S, V, N and Z.
- R8: Code 10 gives 0xFF − d, writes C = 1 and V = 0 with N, Z and S, and keeps H.
- R9: Codes 14 to 18 shift d by one place. Rotate left moves C into bit 0, and rotate right moves C into bit 7. Arithmetic shift right keeps bit 7. C takes the bit shifted out, V = N xor C, and N, Z and S are written. H is kept.
- R10: Code 19 swaps the nibbles of d and code 20 returns 0xFF. Neither changes any flag.
- R11: On a clock edge with `op_valid` high, `flags_q` loads `flags_out`. With `op_valid` low, `flags_q` holds its value.
- R12: Codes 21 to 31 give result 0, `result_we` 0 and `flags_out` = `flags_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the status register |
| op_valid | input | 1 | Load the new status vector at this edge |
| op_code | input | 5 | Operation select |
| opnd_d | input | 8 | Destination operand |
| opnd_r | input | 8 | Source operand or immediate |
| flags_in | input | 6 | Current status vector, carry at bit 0 |
| result | output | 8 | Operation result |
| result_we | output | 1 | Result should be written back |
| flags_out | output | 6 | Status vector after the operation |
| flags_q | output | 6 | Registered status vector |

## Verification
Every two-operand operation is swept over all 65536 operand pairs, once with the incoming carry at 0 and once at 1. This sweep hits every carry, borrow and half-carry boundary and every signed-overflow boundary. The incoming zero bit and the other kept bits change with the operand bits, so the sweep separates a chained zero from a plain zero and catches any bit that should have been kept but was overwritten. One-operand operations and the unused codes are swept over all 256 values with both carries. This covers the increment and decrement overflow points, the bit carried in and out by the rotates, and the sign-preserving right shift. Short clocked sequences then check the reset value, a load of the status register and holding it while `op_valid` is low.

// File: rtl/alu8_pkg.sv
// Shared operation codes, flag bit positions and flag-group decoding for the
// eight-bit ALU. Assumes a 5-bit operation select; codes above OP_SER are unused.
package alu8_pkg;

    localparam int FLAG_W = 6;
    localparam int FL_C   = 0;
    localparam int FL_Z   = 1;
    localparam int FL_N   = 2;
    localparam int FL_V   = 3;
    localparam int FL_S   = 4;
    localparam int FL_H   = 5;

    typedef enum logic [4:0] {
        OP_ADD  = 5'd0,  OP_ADC  = 5'd1,  OP_SUB  = 5'd2,  OP_SBC  = 5'd3,
        OP_CMP  = 5'd4,  OP_CMPC = 5'd5,  OP_NEG  = 5'd6,  OP_AND  = 5'd7,
        OP_OR   = 5'd8,  OP_XOR  = 5'd9,  OP_COM  = 5'd10, OP_INC  = 5'd11,
        OP_DEC  = 5'd12, OP_TST  = 5'd13, OP_LSL  = 5'd14, OP_LSR  = 5'd15,
        OP_ROL  = 5'd16, OP_ROR  = 5'd17, OP_ASR  = 5'd18, OP_SWAP = 5'd19,
        OP_SER  = 5'd20
    } alu_op_e;

    typedef enum logic [1:0] {
        CL_ARITH, CL_LOGIC, CL_SHIFT, CL_NONE
    } op_class_e;

    // Which datapath unit serves an operation.
    function automatic op_class_e op_class(input alu_op_e op);
        case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP, OP_CMPC, OP_NEG:
                return CL_ARITH;
            OP_AND, OP_OR, OP_XOR, OP_COM, OP_INC, OP_DEC, OP_TST:
                return CL_LOGIC;
            OP_LSL, OP_LSR, OP_ROL, OP_ROR, OP_ASR, OP_SWAP, OP_SER:
                return CL_SHIFT;
            default:
                return CL_NONE;
        endcase
    endfunction

    // Flag bits an operation is allowed to rewrite.
    function automatic logic [FLAG_W-1:0] flag_mask(input alu_op_e op);
        logic [FLAG_W-1:0] m;
        m = '0;
        case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP, OP_CMPC, OP_NEG:
                m = '1;
            OP_AND, OP_OR, OP_XOR, OP_INC, OP_DEC, OP_TST: begin
                m[FL_S] = 1'b1; m[FL_V] = 1'b1; m[FL_N] = 1'b1; m[FL_Z] = 1'b1;
            end
            OP_COM, OP_LSL, OP_LSR, OP_ROL, OP_ROR, OP_ASR: begin
                m[FL_S] = 1'b1; m[FL_V] = 1'b1; m[FL_N] = 1'b1; m[FL_Z] = 1'b1;
                m[FL_C] = 1'b1;
            end
            default: m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/alu8_arith.sv
// Add/subtract unit: add, add with carry, subtract, subtract with carry,
// compares and negate. Produces result and the H, V, C, Z candidates.
// Assumes DATA_W is even so a half-width carry exists.
module alu8_arith
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    input  logic              zin,
    output logic [DATA_W-1:0] res,
    output logic              h_o,
    output logic              v_o,
    output logic              c_o,
    output logic              z_o
);
    localparam int HALF = DATA_W / 2;
    localparam int MSB  = DATA_W - 1;

    logic              is_sub, use_c, chain;
    logic [DATA_W-1:0] opa, opb;
    logic [DATA_W:0]   full;
    logic [HALF:0]     half;
    logic              cx;

    // Decode subtraction, carry use and zero chaining from the operation.
    always_comb begin
        is_sub = (op == OP_SUB) || (op == OP_SBC) || (op == OP_CMP) ||
                 (op == OP_CMPC) || (op == OP_NEG);
        use_c  = (op == OP_ADC) || (op == OP_SBC) || (op == OP_CMPC);
        chain  = (op == OP_SBC) || (op == OP_CMPC);
        opa    = (op == OP_NEG) ? '0 : a;
        opb    = (op == OP_NEG) ? a  : b;
        cx     = use_c & cin;
    end

    // Full-width and half-width sums give carry/borrow from the top and bit 3.
    always_comb begin
        if (is_sub) begin
            full = {1'b0, opa} - {1'b0, opb} - {{DATA_W{1'b0}}, cx};
            half = {1'b0, opa[HALF-1:0]} - {1'b0, opb[HALF-1:0]} - {{HALF{1'b0}}, cx};
        end else begin
            full = {1'b0, opa} + {1'b0, opb} + {{DATA_W{1'b0}}, cx};
            half = {1'b0, opa[HALF-1:0]} + {1'b0, opb[HALF-1:0]} + {{HALF{1'b0}}, cx};
        end
    end

    // Result and flag candidates.
    always_comb begin
        res = full[DATA_W-1:0];
        c_o = full[DATA_W];
        h_o = half[HALF];
        if (is_sub)
            v_o = (opa[MSB] & ~opb[MSB] & ~res[MSB]) | (~opa[MSB] & opb[MSB] & res[MSB]);
        else
            v_o = (opa[MSB] & opb[MSB] & ~res[MSB]) | (~opa[MSB] & ~opb[MSB] & res[MSB]);
        z_o = (res == '0) & (chain ? zin : 1'b1);
    end

endmodule

// File: rtl/alu8_logic.sv
// Bitwise and unary-count unit: and, or, xor, complement, increment,
// decrement and test. Produces result plus V and C candidates.
module alu8_logic
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] res,
    output logic              v_o,
    output logic              c_o
);
    localparam logic [DATA_W-1:0] POS_MAX = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] NEG_MIN = {1'b1, {(DATA_W-1){1'b0}}};

    // Select the bitwise or counting result and its overflow rule.
    always_comb begin
        res = a;
        v_o = 1'b0;
        c_o = 1'b0;
        case (op)
            OP_AND: res = a & b;
            OP_OR:  res = a | b;
            OP_XOR: res = a ^ b;
            OP_COM: begin res = ~a; c_o = 1'b1; end
            OP_INC: begin res = a + 1'b1; v_o = (a == POS_MAX); end
            OP_DEC: begin res = a - 1'b1; v_o = (a == NEG_MIN); end
            default: res = a;
        endcase
    end

endmodule

// File: rtl/alu8_shift.sv
// Single-place shift/rotate unit plus nibble swap and set-all. Produces
// result, the shifted-out carry and V = N xor C.
module alu8_shift
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic              cin,
    output logic [DATA_W-1:0] res,
    output logic              v_o,
    output logic              c_o
);
    localparam int HALF = DATA_W / 2;
    localparam int MSB  = DATA_W - 1;

    // Move bits one place and capture the bit that leaves.
    always_comb begin
        res = a;
        c_o = 1'b0;
        case (op)
            OP_LSL:  begin res = {a[MSB-1:0], 1'b0};   c_o = a[MSB]; end
            OP_LSR:  begin res = {1'b0, a[MSB:1]};     c_o = a[0];   end
            OP_ROL:  begin res = {a[MSB-1:0], cin};    c_o = a[MSB]; end
            OP_ROR:  begin res = {cin, a[MSB:1]};      c_o = a[0];   end
            OP_ASR:  begin res = {a[MSB], a[MSB:1]};   c_o = a[0];   end
            OP_SWAP: res = {a[HALF-1:0], a[MSB:HALF]};
            OP_SER:  res = '1;
            default: res = a;
        endcase
        v_o = res[MSB] ^ c_o;
    end

endmodule

// File: rtl/alu8_flags.sv
// Top of the ALU: routes the operation to one of three units, forms the
// full flag candidate vector, merges it into the incoming flags through the
// per-operation mask, and keeps a status register loaded on op_valid.
// Assumes operand selection (register or immediate) happens upstream.
module alu8_flags
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [4:0]        op_code,
    input  logic [DATA_W-1:0] opnd_d,
    input  logic [DATA_W-1:0] opnd_r,
    input  logic [FLAG_W-1:0] flags_in,
    output logic [DATA_W-1:0] result,
    output logic              result_we,
    output logic [FLAG_W-1:0] flags_out,
    output logic [FLAG_W-1:0] flags_q
);
    alu_op_e           op;
    op_class_e         cls;
    logic [DATA_W-1:0] ar_res, lg_res, sh_res;
    logic              ar_h, ar_v, ar_c, ar_z;
    logic              lg_v, lg_c, sh_v, sh_c;
    logic              h_c, v_c, c_c, z_c, n_c;
    logic [FLAG_W-1:0] cand, mask;

    assign op  = alu_op_e'(op_code);
    assign cls = op_class(op);

    alu8_arith #(.DATA_W(DATA_W)) u_arith (
        .op(op), .a(opnd_d), .b(opnd_r), .cin(flags_in[FL_C]), .zin(flags_in[FL_Z]),
        .res(ar_res), .h_o(ar_h), .v_o(ar_v), .c_o(ar_c), .z_o(ar_z)
    );

    alu8_logic #(.DATA_W(DATA_W)) u_logic (
        .op(op), .a(opnd_d), .b(opnd_r), .res(lg_res), .v_o(lg_v), .c_o(lg_c)
    );

    alu8_shift #(.DATA_W(DATA_W)) u_shift (
        .op(op), .a(opnd_d), .cin(flags_in[FL_C]), .res(sh_res), .v_o(sh_v), .c_o(sh_c)
    );

    // Pick the serving unit's result and flag candidates.
    always_comb begin
        result = '0;
        h_c = 1'b0; v_c = 1'b0; c_c = 1'b0;
        case (cls)
            CL_ARITH: begin result = ar_res; h_c = ar_h; v_c = ar_v; c_c = ar_c; end
            CL_LOGIC: begin result = lg_res; v_c = lg_v; c_c = lg_c; end
            CL_SHIFT: begin result = sh_res; v_c = sh_v; c_c = sh_c; end
            default:  result = '0;
        endcase
        n_c = result[DATA_W-1];
        z_c = (cls == CL_ARITH) ? ar_z : (result == '0);
    end

    // Assemble candidates and merge only the bits this operation owns.
    always_comb begin
        cand        = '0;
        cand[FL_C]  = c_c;
        cand[FL_Z]  = z_c;
        cand[FL_N]  = n_c;
        cand[FL_V]  = v_c;
        cand[FL_S]  = n_c ^ v_c;
        cand[FL_H]  = h_c;
        mask        = flag_mask(op);
        flags_out   = (flags_in & ~mask) | (cand & mask);
        result_we   = (cls != CL_NONE) && (op != OP_CMP) && (op != OP_CMPC);
    end

    // Status register: cleared by reset, loaded when an operation retires.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flags_q <= '0;
        else if (op_valid)
            flags_q <= flags_out;
    end

endmodule

// File: rtl/alu8_flags_chk.sv
// Property checker for alu8_flags, attached by bind below. Observes ports only.
module alu8_flags_chk
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic [4:0]        op_code,
    input logic [FLAG_W-1:0] flags_in,
    input logic [DATA_W-1:0] result,
    input logic              result_we,
    input logic [FLAG_W-1:0] flags_out,
    input logic [FLAG_W-1:0] flags_q
);
    logic is_shift, is_chain, is_cmp, is_keep, is_unused;
    assign is_shift  = (op_code >= 5'd14) && (op_code <= 5'd18);
    assign is_chain  = (op_code == 5'd3) || (op_code == 5'd5);
    assign is_cmp    = (op_code == 5'd4) || (op_code == 5'd5);
    assign is_keep   = (op_code == 5'd19) || (op_code == 5'd20);
    assign is_unused = (op_code > 5'd20);

    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> flags_q == '0);

    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(flags_q));

    a_r4_chain_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (is_chain && !flags_in[FL_Z]) |-> !flags_out[FL_Z]);

    a_r5_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        is_cmp |-> !result_we);

    a_r8_com_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 5'd10) |-> (flags_out[FL_C] && !flags_out[FL_V]));

    a_r9_shift_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        is_shift |-> (flags_out[FL_V] == (result[DATA_W-1] ^ flags_out[FL_C])));

    a_r10_no_flags: assert property (@(posedge clk) disable iff (!rst_n)
        is_keep |-> (flags_out == flags_in));

    a_r12_unused_code: assert property (@(posedge clk) disable iff (!rst_n)
        is_unused |-> (result == '0 && !result_we && flags_out == flags_in));

endmodule

bind alu8_flags alu8_flags_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/alu8_flags_bench.sv
// Exhaustive operand sweep of alu8_flags against an arithmetic model, then
// clocked checks of the status register.
module alu8_flags_bench;
    timeunit 1ns;
    timeprecision 10ps;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [4:0] op_code = '0;
    logic [7:0] opnd_d = '0;
    logic [7:0] opnd_r = '0;
    logic [5:0] flags_in = '0;
    logic [7:0] result;
    logic       result_we;
    logic [5:0] flags_out;
    logic [5:0] flags_q;

    int n_vec = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    alu8_flags u_alu8_flags (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .opnd_d(opnd_d), .opnd_r(opnd_r), .flags_in(flags_in),
        .result(result), .result_we(result_we), .flags_out(flags_out),
        .flags_q(flags_q)
    );

    always #2.5 clk = ~clk;

    // Watchdog: a hung run counts as one miscompare and still reports.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000 && !done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: actual cycles=%0d expected < 190000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    function automatic string req_tag(input int op);
        case (op)
            0, 1:           return "R2";
            2, 6:           return "R3";
            3, 5:           return "R4";
            4:              return "R5";
            7, 8, 9, 13:    return "R6";
            11, 12:         return "R7";
            10:             return "R8";
            14, 15, 16, 17, 18: return "R9";
            19, 20:         return "R10";
            default:        return "R12";
        endcase
    endfunction

    function automatic int sgn(input int x);
        return (x > 127) ? x - 256 : x;
    endfunction

    // Arithmetic model written from the requirements.
    task automatic ref_model(input int op, input int a, input int b, input logic [5:0] fin,
                             output int r, output bit we, output logic [5:0] fo);
        int t, sr, cc;
        bit c, z, n, v, h, s;
        logic [5:0] m;
        cc = fin[0] ? 1 : 0;
        c = fin[0]; h = fin[5]; v = 1'b0; we = 1'b1; m = 6'h00; r = 0;
        case (op)
            0, 1: begin
                if (op == 0) cc = 0;
                t = a + b + cc; r = t & 255; c = (t > 255);
                h = ((a & 15) + (b & 15) + cc) > 15;
                sr = sgn(a) + sgn(b) + cc; v = (sr > 127) || (sr < -128);
                m = 6'h3F;
            end
            2, 3, 4, 5: begin
                if (op == 2 || op == 4) cc = 0;
                t = a - b - cc; r = t & 255; c = (t < 0);
                h = ((a & 15) - (b & 15) - cc) < 0;
                sr = sgn(a) - sgn(b) - cc; v = (sr > 127) || (sr < -128);
                m = 6'h3F; we = !(op == 4 || op == 5);
            end
            6: begin
                t = 0 - a; r = t & 255; c = (t < 0);
                h = (0 - (a & 15)) < 0;
                sr = 0 - sgn(a); v = (sr > 127);
                m = 6'h3F;
            end
            7:  begin r = a & b; m = 6'h1E; end
            8:  begin r = a | b; m = 6'h1E; end
            9:  begin r = a ^ b; m = 6'h1E; end
            13: begin r = a;     m = 6'h1E; end
            11: begin r = (a + 1) & 255; v = (a == 127); m = 6'h1E; end
            12: begin r = (a + 255) & 255; v = (a == 128); m = 6'h1E; end
            10: begin r = 255 - a; c = 1'b1; m = 6'h1F; end
            14: begin r = (a << 1) & 255;           c = a[7]; m = 6'h1F; end
            15: begin r = a >> 1;                    c = a[0]; m = 6'h1F; end
            16: begin r = ((a << 1) | cc) & 255;     c = a[7]; m = 6'h1F; end
            17: begin r = (a >> 1) | (cc << 7);      c = a[0]; m = 6'h1F; end
            18: begin r = (a >> 1) | (a & 128);      c = a[0]; m = 6'h1F; end
            19: r = ((a & 15) << 4) | (a >> 4);
            20: r = 255;
            default: begin r = 0; we = 1'b0; end
        endcase
        n = (r >= 128);
        z = (r == 0);
        if (op == 3 || op == 5) z = z && fin[1];
        if (op >= 14 && op <= 18) v = n ^ c;
        s = n ^ v;
        fo = fin;
        if (m[0]) fo[0] = c;
        if (m[1]) fo[1] = z;
        if (m[2]) fo[2] = n;
        if (m[3]) fo[3] = v;
        if (m[4]) fo[4] = s;
        if (m[5]) fo[5] = h;
    endtask

    task automatic apply_vec(input int op, input int a, input int b, input logic [5:0] fin);
        int r;
        bit we;
        logic [5:0] fo;
        op_code  = 5'(op);
        opnd_d   = 8'(a);
        opnd_r   = 8'(b);
        flags_in = fin;
        #0.1;
        ref_model(op, a, b, fin, r, we, fo);
        n_vec++;
        if (result !== 8'(r) || result_we !== we || flags_out !== fo) begin
            n_bad++;
            $display("FAIL %s op=%0d d=%02h r=%02h fin=%02h: actual res=%02h we=%0b fl=%02h expected res=%02h we=%0b fl=%02h",
                     req_tag(op), op, a, b, fin, result, result_we, flags_out, 8'(r), we, fo);
        end
    endtask

    task automatic check_q(input string tag, input logic [5:0] exp);
        n_vec++;
        if (flags_q !== exp) begin
            n_bad++;
            $display("FAIL %s flags_q: actual %02h expected %02h", tag, flags_q, exp);
        end
    endtask

    initial begin
        logic [5:0] hold_val;
        // R1: reset clears the status register.
        repeat (3) @(posedge clk);
        #1 check_q("R1", 6'h00);
        @(negedge clk) rst_n = 1'b1;

        // Exhaustive combinational sweep; op_valid stays low (R11 hold).
        for (int op = 0; op < 32; op++) begin
            bit binary;
            binary = (op <= 5) || (op >= 7 && op <= 9);
            for (int a = 0; a < 256; a++) begin
                for (int b = 0; b < (binary ? 256 : 1); b++) begin
                    for (int cc = 0; cc < 2; cc++) begin
                        int bb;
                        logic [5:0] fin;
                        bb = binary ? b : (a ^ 8'h5A);
                        fin = {bb[7] ^ a[3], a[0] ^ bb[3], bb[2], a[5], a[1] ^ bb[4], cc[0]};
                        apply_vec(op, a, bb, fin);
                    end
                end
            end
        end
        check_q("R11", 6'h00);

        // R11: load on op_valid. 0x80 + 0x80 -> S,V,Z,C set = 0x1B.
        @(negedge clk);
        op_valid = 1'b1; op_code = 5'd0; opnd_d = 8'h80; opnd_r = 8'h80; flags_in = 6'h00;
        @(posedge clk); #1 check_q("R11", 6'h1B);
        // R11: hold with op_valid low while inputs change.
        @(negedge clk);
        op_valid = 1'b0; op_code = 5'd7; opnd_d = 8'hF0; opnd_r = 8'h0F; flags_in = 6'h20;
        hold_val = 6'h1B;
        repeat (2) @(posedge clk);
        #1 check_q("R11", hold_val);
        // R11: second load, AND -> 0 with H kept: Z and H = 0x22.
        @(negedge clk) op_valid = 1'b1;
        @(posedge clk); #1 check_q("R11", 6'h22);
        // R1: reset again mid-run.
        @(negedge clk) begin op_valid = 1'b0; rst_n = 1'b0; end
        @(posedge clk); #1 check_q("R1", 6'h00);
        @(negedge clk) rst_n = 1'b1;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule